// File: doc/BRIEF.md
# Line-Bounded Multi-Word Read Request Splitter

This block turns a non-cacheable load of one to four consecutive 32-bit words into one or two read-address requests on an AXI read address channel. Each request carries the start byte address, an incrementing burst type, a beat size and a beat count. The beat size and count depend on three things: the number of words, whether the start address is on an 8-byte boundary, and the memory type of the load. The memory type is either strongly-ordered/device, or normal non-cacheable (which also covers loads made while the cache is disabled).

A 32-byte line is the unit of alignment. If the words would run past the end of the line, the load is cut in two. The first request covers the words up to the end of the line. The second covers the remaining words and starts at byte zero of the same line. Each part is encoded by the same rules as an unsplit load of its own word count at its own alignment, and both parts use the memory type of the original load.

The input side and the AR side each use a valid/ready handshake. One load is held inside the block at a time.

Top module: `ldm_burst_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `ar_valid` is 0.
- R2: Every request has `ar_burst` = 2'b01 (incrementing), and the first request of a load has `ar_addr` equal to the accepted `req_addr`.
- R3: A part of one word is sent with `ar_size` = 2 (32-bit beats) and `ar_len` = 0.
- R4: A part of two to four words whose start address has bit 2 clear is sent with `ar_size` = 3 (64-bit beats) and ceil(words/2) beats, so `ar_len` = ceil(words/2) - 1. This holds for both memory types.
- R5: A part of two to four words whose start address has bit 2 set, on a device load (`req_dev` = 1), is sent with `ar_size` = 2 and one beat per word, so `ar_len` = words - 1.
- R6: A part of two to four words whose start address has bit 2 set, on a normal load (`req_dev` = 0), is sent with `ar_size` = 3 and ceil((words+1)/2) beats. For example, four words give `ar_len` = 2.
- R7: Let the word index be `req_addr[4:2]`. When index + words > 8, two requests are sent. The first is (8 - index) words at `req_addr`. The second is the remaining words at `req_addr` with bits 4:0 cleared. Each part is encoded by R3 to R6.
- R8: The second request is presented only after the first has been accepted. `req_ready` stays 0 from acceptance until the last request is accepted. While `ar_valid` is 1 and `ar_ready` is 0, all AR fields hold.
- R9: `ar_valid` rises in the cycle after a load is accepted. `req_ready` returns to 1 in the cycle after the last request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load request is offered |
| req_ready | output | 1 | The block can take a load request |
| req_addr | input | ADDR_W | Byte address of the first word (word aligned) |
| req_words | input | 3 | Number of words, 1 to 4 |
| req_dev | input | 1 | 1 for strongly-ordered/device, 0 for normal non-cacheable or cache disabled |
| ar_valid | output | 1 | Read address request valid |
| ar_ready | input | 1 | Read address request accepted |
| ar_addr | output | ADDR_W | Request start byte address |
| ar_burst | output | 2 | Burst type (incrementing) |
| ar_size | output | 3 | Beat size code (2 = 32-bit, 3 = 64-bit) |
| ar_len | output | 8 | Beats minus one |

## Verification
A wrong word count in the split logic, or a state machine that drops or repeats a phase, shows up at the ports in the very next AR request. It appears either as a wrong `ar_len` or `ar_size` on one of the parts, or as a second request that is missing, extra, or not at the line base. A state that fails to return to idle shows up as `req_ready` still low one cycle after the last acceptance. The bench samples every request at its first valid cycle. It also stalls `ar_ready` to show that the fields hold and that the second part does not appear early.

// File: rtl/ldm_pkg.sv
// Shared constants and types for the multi-word read request splitter.
// Assumes an AXI-style read address channel with 8-bit length and 3-bit size.
package ldm_pkg;
    localparam int          LEN_W      = 8;
    localparam int          SIZE_W     = 3;
    localparam logic [1:0]  BURST_INCR = 2'b01;
    localparam int          WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } ldm_state_e;
endpackage

// File: rtl/ldm_split.sv
// Cuts a load at the end of its line.
// Reports how many words fall before the line end, how many wrap, and the
// byte address of the line base.
// Assumes a word-aligned address and a count of at most the words in one line.
module ldm_split #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic              need_split,
    output logic [CNT_W-1:0]  first_cnt,
    output logic [CNT_W-1:0]  second_cnt,
    output logic [ADDR_W-1:0] base_addr
);
    localparam int OFS_W     = $clog2(LINE_BYTES);
    localparam int IDX_W     = OFS_W - 2;
    localparam int WORDS_PL  = LINE_BYTES / ldm_pkg::WORD_BYTES;

    logic [IDX_W-1:0] idx;
    int               room;

    // Purpose: find the words left before the line end and divide the count.
    always_comb begin
        idx        = addr[OFS_W-1:2];
        room       = WORDS_PL - int'(idx);
        need_split = int'(cnt) > room;
        if (need_split) begin
            first_cnt  = CNT_W'(room);
            second_cnt = cnt - CNT_W'(room);
        end else begin
            first_cnt  = cnt;
            second_cnt = '0;
        end
        base_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    end
endmodule

// File: rtl/ldm_encode.sv
// Chooses the beat size and beat count for one part of a load.
// Inputs are the part's word count, bit 2 of its start address, and the
// memory type. Assumes a count of 1 to 4.
module ldm_encode #(
    parameter int CNT_W = 3
) (
    input  logic                        half_off,
    input  logic                        dev,
    input  logic [CNT_W-1:0]            cnt,
    output logic [ldm_pkg::SIZE_W-1:0]  size,
    output logic [ldm_pkg::LEN_W-1:0]   len
);
    logic [CNT_W:0] cnt_x;
    logic [CNT_W:0] beats;

    // Purpose: choose 32- or 64-bit beats and count beats to cover the span.
    always_comb begin
        cnt_x = {1'b0, cnt};
        if (cnt == CNT_W'(1)) begin
            size  = 3'd2;
            beats = (CNT_W+1)'(1);
        end else if (!half_off) begin
            size  = 3'd3;
            beats = (cnt_x + (CNT_W+1)'(1)) >> 1;
        end else if (dev) begin
            size  = 3'd2;
            beats = cnt_x;
        end else begin
            size  = 3'd3;
            beats = (cnt_x + (CNT_W+1)'(2)) >> 1;
        end
        len = ldm_pkg::LEN_W'(beats) - ldm_pkg::LEN_W'(1);
    end
endmodule

// File: rtl/ldm_burst_gen.sv
// Holds one accepted multi-word load and issues its one or two read requests.
// The second request wraps to the line base.
// Assumes req_words is 1 to 4 and req_addr is word aligned.
module ldm_burst_gen #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_words,
    input  logic              req_dev,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [2:0]        ar_size,
    output logic [7:0]        ar_len
);
    import ldm_pkg::*;

    localparam int CNT_W = 3;
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int PARTS = 2;

    ldm_state_e        st;
    logic [ADDR_W-1:0] r_addr;
    logic [CNT_W-1:0]  r_cnt;
    logic              r_dev;

    logic              need_split;
    logic [CNT_W-1:0]  cnt_first, cnt_second;
    logic [ADDR_W-1:0] base_addr;

    logic [ADDR_W-1:0] p_addr [PARTS];
    logic [CNT_W-1:0]  p_cnt  [PARTS];
    logic [SIZE_W-1:0] p_size [PARTS];
    logic [LEN_W-1:0]  p_len  [PARTS];

    logic req_fire, ar_fire;
    assign req_fire = req_valid && req_ready;
    assign ar_fire  = ar_valid && ar_ready;

    // Purpose: capture the load and step through its request phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            r_addr <= '0;
            r_cnt  <= '0;
            r_dev  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_fire) begin
                    r_addr <= req_addr;
                    r_cnt  <= req_words;
                    r_dev  <= req_dev;
                    st     <= ST_FIRST;
                end
                ST_FIRST: if (ar_fire) st <= need_split ? ST_SECOND : ST_IDLE;
                ST_SECOND: if (ar_fire) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    ldm_split #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_split (
        .addr       (r_addr),
        .cnt        (r_cnt),
        .need_split (need_split),
        .first_cnt  (cnt_first),
        .second_cnt (cnt_second),
        .base_addr  (base_addr)
    );

    assign p_addr[0] = r_addr;
    assign p_cnt[0]  = cnt_first;
    assign p_addr[1] = base_addr;
    assign p_cnt[1]  = cnt_second;

    for (genvar p = 0; p < PARTS; p++) begin : g_part
        ldm_encode #(.CNT_W(CNT_W)) u_enc (
            .half_off (p_addr[p][2]),
            .dev      (r_dev),
            .cnt      (p_cnt[p]),
            .size     (p_size[p]),
            .len      (p_len[p])
        );
    end

    // Purpose: present the part selected by the current phase.
    always_comb begin
        req_ready = (st == ST_IDLE);
        ar_valid  = (st != ST_IDLE);
        ar_burst  = BURST_INCR;
        if (st == ST_SECOND) begin
            ar_addr = p_addr[1];
            ar_size = p_size[1];
            ar_len  = p_len[1];
        end else begin
            ar_addr = p_addr[0];
            ar_size = p_size[0];
            ar_len  = p_len[0];
        end
    end

    AST_WORDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> (req_words >= 3'd1 && req_words <= 3'd4));  // R7
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> ar_valid && ar_addr == $past(req_addr));  // R2
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> ar_valid && $stable(ar_addr)
            && $stable(ar_size) && $stable(ar_len));  // R8
    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !req_ready);  // R8
    AST_SECOND_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SECOND) |-> ar_addr[OFS_W-1:0] == '0);  // R7
    AST_STAYS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (((int'(ar_addr[OFS_W-1:0]) >> ar_size) << ar_size)
            + ((int'(ar_len) + 1) << ar_size)) <= LINE_BYTES);  // R7
    AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (int'(cnt_first) + int'(cnt_second)) == int'(r_cnt));  // R7
endmodule

// File: tb/ldm_burst_gen_bench.sv
module ldm_burst_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [2:0]  req_words;
    logic        req_dev;
    logic        ar_valid;
    logic        ar_ready;
    logic [31:0] ar_addr;
    logic [1:0]  ar_burst;
    logic [2:0]  ar_size;
    logic [7:0]  ar_len;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ldm_burst_gen u_ldm_burst_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_words(req_words), .req_dev(req_dev),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .ar_burst(ar_burst), .ar_size(ar_size), .ar_len(ar_len)
    );

    localparam logic [31:0] LINE = 32'h1000_0040;
    localparam int NV = 16;
    // Fields: offset[26:19] words[18:16] dev[15] split[14]
    //         size0[13:11] len0[10:7] size1[6:4] len1[3:0]
    localparam logic [26:0] VEC [NV] = '{
        {8'h00, 3'd4, 1'b1, 1'b0, 3'd3, 4'd1, 3'd0, 4'd0},  // R4
        {8'h04, 3'd4, 1'b1, 1'b0, 3'd2, 4'd3, 3'd0, 4'd0},  // R5
        {8'h08, 3'd4, 1'b0, 1'b0, 3'd3, 4'd1, 3'd0, 4'd0},  // R4
        {8'h0C, 3'd4, 1'b0, 1'b0, 3'd3, 4'd2, 3'd0, 4'd0},  // R6
        {8'h10, 3'd4, 1'b1, 1'b0, 3'd3, 4'd1, 3'd0, 4'd0},  // R4
        {8'h14, 3'd4, 1'b1, 1'b1, 3'd2, 4'd2, 3'd2, 4'd0},  // R7
        {8'h14, 3'd4, 1'b0, 1'b1, 3'd3, 4'd1, 3'd2, 4'd0},  // R7
        {8'h18, 3'd4, 1'b0, 1'b1, 3'd3, 4'd0, 3'd3, 4'd0},  // R7
        {8'h1C, 3'd4, 1'b1, 1'b1, 3'd2, 4'd0, 3'd3, 4'd1},  // R7
        {8'h00, 3'd1, 1'b0, 1'b0, 3'd2, 4'd0, 3'd0, 4'd0},  // R3
        {8'h04, 3'd2, 1'b1, 1'b0, 3'd2, 4'd1, 3'd0, 4'd0},  // R5
        {8'h04, 3'd2, 1'b0, 1'b0, 3'd3, 4'd1, 3'd0, 4'd0},  // R6
        {8'h08, 3'd3, 1'b0, 1'b0, 3'd3, 4'd1, 3'd0, 4'd0},  // R4
        {8'h0C, 3'd3, 1'b1, 1'b0, 3'd2, 4'd2, 3'd0, 4'd0},  // R5
        {8'h1C, 3'd2, 1'b0, 1'b1, 3'd2, 4'd0, 3'd2, 4'd0},  // R7
        {8'h1C, 3'd1, 1'b1, 1'b0, 3'd2, 4'd0, 3'd0, 4'd0}   // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_part(input string req, input logic [31:0] a,
                              input logic [2:0] s, input logic [3:0] l);
        check({req, " valid"}, 32'(ar_valid), 32'd1);
        check({req, " addr"},  ar_addr, a);
        check({req, " R2 burst"}, 32'(ar_burst), 32'd1);
        check({req, " size"},  32'(ar_size), 32'(s));
        check({req, " len"},   32'(ar_len), 32'(l));
    endtask

    // Purpose: offer one load and walk its AR requests, stalling if asked.
    task automatic run_vec(input int i, input bit stall);
        logic [26:0] v;
        logic [31:0] a;
        string tag;
        v = VEC[i];
        a = LINE + 32'(v[26:19]);
        tag = v[14] ? "R7" : "R4/R5/R6/R3";
        @(negedge clk);
        req_addr = a; req_words = v[18:16]; req_dev = v[15]; req_valid = 1'b1;
        ar_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 busy after accept", 32'(req_ready), 32'd0);
        check_part({tag, " first"}, a, v[13:11], v[10:7]);
        if (stall) begin
            @(negedge clk);
            check_part("R8 held under stall", a, v[13:11], v[10:7]);
        end
        ar_ready = 1'b1;
        @(negedge clk);
        ar_ready = 1'b0;
        if (v[14]) begin
            check("R8 busy between parts", 32'(req_ready), 32'd0);
            check_part("R7 second", LINE, v[6:4], v[3:0]);
            if (stall) begin
                @(negedge clk);
                check_part("R8 second held", LINE, v[6:4], v[3:0]);
            end
            ar_ready = 1'b1;
            @(negedge clk);
            ar_ready = 1'b0;
        end
        check("R9 idle ar_valid", 32'(ar_valid), 32'd0);
        check("R9 ready again", 32'(req_ready), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_words = 3'd1;
        req_dev = 1'b0; ar_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset req_ready", 32'(req_ready), 32'd1);
        check("R1 reset ar_valid", 32'(ar_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset ar_valid", 32'(ar_valid), 32'd0);
        for (int i = 0; i < NV; i++) run_vec(i, (i % 2) == 1);
        // Directed: offer with no ready while busy must not replace held load (R8).
        @(negedge clk);
        req_addr = LINE + 32'h14; req_words = 3'd4; req_dev = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_addr = LINE + 32'h00; req_words = 3'd1; req_dev = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check_part("R8 held load unchanged", LINE + 32'h14, 3'd2, 4'd2);
        ar_ready = 1'b1;
        @(negedge clk);
        check_part("R7 second after directed", LINE, 3'd2, 4'd0);
        @(negedge clk);
        ar_ready = 1'b0;
        check("R9 ready after directed", 32'(req_ready), 32'd1);
        // Directed: reset in the middle of a split load (R1).
        req_addr = LINE + 32'h18; req_words = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-load reset ar_valid", 32'(ar_valid), 32'd0);
        check("R1 mid-load reset req_ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                runs++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule